// File: doc/BRIEF.md
# Constant Times-Fourteen Multiplier

This block is a purely combinational datapath unit that scales a signed two's-complement operand by the fixed factor fourteen. It does not use a general multiplier array. It breaks the constant into a few left shifts of the operand and combines them with adders.

The operand is 16 bits by default. The product is four bits wider, so no input value can overflow it. The unit has no clock, no reset and no handshake: the product follows the operand after the propagation delay of the adder network.

A build-time parameter picks one of two structures:

- **Variant 0** sums the copies shifted left by three, two and one. A row of full adders compresses the three terms to two, and a single carry-propagate adder finishes the sum.
- **Variant 1** takes the copy shifted left by one away from the copy shifted left by four, using one subtractor.

Both variants give the same product for every operand.

Top module: `times14_mul`

## Requirements
- R1: For every 16-bit signed operand A, `product_o` read as a 20-bit two's-complement value equals A×14.
- R2: With VARIANT=0 the product is built by compressing A·8, A·4 and A·2 (each sign-extended to 20 bits) through a full-adder carry-save row, followed by one carry-propagate addition.
- R3: The carry-save row keeps the total: its sum vector plus twice its carry vector equals the sum of its three inputs, modulo 2^20.
- R4: Bit 0 of `product_o` is always 0.
- R5: For a nonzero operand, bit 19 of `product_o` equals bit 15 of `operand_i`. A negative operand gives a negative product and a positive operand gives a positive one.
- R6: The extreme operands give exact results:
  - operand 0x7FFF gives 458738 (0x6FFF2);
  - operand 0x8000 gives −458752 (0x90000).
- R7: With VARIANT=1 the product is A·16 minus A·2, with the subtrahend sign-extended by three bits. This build gives the same output as VARIANT=0 for every operand.
- R8: Operand 0 gives product 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 16 | Signed two's-complement multiplicand |
| product_o | output | 20 | Signed two's-complement product, operand times 14 |

## Verification
The two builds are instantiated side by side and driven with the same operands. Each output is compared with a product computed in the bench.

Directed operands cover the following cases:
- Zero, plus one and minus one separate sign handling from the magnitude path.
- The two extreme values show whether the four extra output bits are sign-extended correctly.
- All-ones, 0x5555 and 0xAAAA put long carry chains and alternating carry patterns into every column of the carry-save row and the final adder.

A block of randomly drawn operands, from a fixed seed, then checks general agreement between the two builds and the reference product.

// File: rtl/times14_pkg.sv
// Package: shared widths for the times-fourteen datapath.
// Assumes the constant 14 needs four extra output bits (14 < 2^4).
package times14_pkg;
    localparam int unsigned T14_IN_W  = 16;
    localparam int unsigned T14_GROW  = 4;
    localparam int unsigned T14_CONST = 14;
endpackage

// File: rtl/t14_fa_cell.sv
// Module: single-bit full adder.
// Assumes nothing beyond three one-bit inputs; purely combinational.
module t14_fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic co_o
);
    // Sum is the parity of the inputs, carry-out is their majority.
    always_comb begin
        s_o  = a_i ^ b_i ^ c_i;
        co_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end
endmodule

// File: rtl/t14_csa_row.sv
// Module: 3:2 carry-save compressor built from one full adder per column.
// Assumes all three inputs are already aligned and extended to W bits.
// The carry vector is returned unshifted; the user shifts it left by one.
module t14_csa_row #(
    parameter int unsigned W = 20
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    // One full adder per bit column.
    for (genvar g = 0; g < W; g++) begin : g_col
        t14_fa_cell u_fa (
            .a_i  (x_i[g]),
            .b_i  (y_i[g]),
            .c_i  (z_i[g]),
            .s_o  (sum_o[g]),
            .co_o (carry_o[g])
        );
    end

    // Checker: compression preserves the total modulo 2^W.
    logic [W-1:0] chk_lhs, chk_rhs;
    always_comb begin
        chk_lhs = sum_o + (carry_o << 1);
        chk_rhs = x_i + y_i + z_i;
        a_r3_csa_conserves: assert (chk_lhs == chk_rhs)
            else $error("R3: carry-save row lost value");
    end
endmodule

// File: rtl/t14_cpa.sv
// Module: W-bit carry-propagate adder or subtractor.
// Assumes two's-complement operands and wraps modulo 2^W.
// SUB=1 forms a - b as a + ~b + 1.
module t14_cpa #(
    parameter int unsigned W   = 20,
    parameter bit          SUB = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    localparam logic [W-1:0] CIN = W'(SUB);

    logic [W-1:0] b_eff;

    // Invert the second operand and inject a carry-in when subtracting.
    always_comb begin
        b_eff = SUB ? ~b_i : b_i;
        y_o   = a_i + b_eff + CIN;
    end
endmodule

// File: rtl/times14_mul.sv
// Module: signed operand times 14, built from shifts and adders.
// VARIANT 0: 8A + 4A + 2A through a carry-save row and one adder.
// VARIANT 1: 16A - 2A through one subtractor.
// Assumes a two's-complement operand; the output grows by four bits,
// so it never overflows. Purely combinational.
module times14_mul
    import times14_pkg::*;
#(
    parameter int unsigned IN_W    = T14_IN_W,
    parameter int unsigned VARIANT = 0
) (
    input  logic [IN_W-1:0]          operand_i,
    output logic [IN_W+T14_GROW-1:0] product_o
);
    localparam int unsigned OUT_W = IN_W + T14_GROW;
    localparam int unsigned MSB   = IN_W - 1;

    logic [OUT_W-1:0] op_ext;

    // Sign-extend the operand to the product width.
    always_comb op_ext = {{T14_GROW{operand_i[MSB]}}, operand_i};

    if (VARIANT == 0) begin : g_csa
        logic [OUT_W-1:0] t8, t4, t2, csa_sum, csa_carry;

        // Form the three shifted terms.
        always_comb begin
            t8 = op_ext << 3;
            t4 = op_ext << 2;
            t2 = op_ext << 1;
        end

        t14_csa_row #(.W(OUT_W)) u_csa (
            .x_i     (t8),
            .y_i     (t4),
            .z_i     (t2),
            .sum_o   (csa_sum),
            .carry_o (csa_carry)
        );

        t14_cpa #(.W(OUT_W), .SUB(1'b0)) u_cpa (
            .a_i (csa_sum),
            .b_i (csa_carry << 1),
            .y_o (product_o)
        );
    end else begin : g_sub
        logic [OUT_W-1:0] minuend, subtrahend;

        // 16A fills the width exactly; 2A gets three sign bits on top.
        always_comb begin
            minuend    = {operand_i, 4'b0000};
            subtrahend = {{3{operand_i[MSB]}}, operand_i, 1'b0};
        end

        t14_cpa #(.W(OUT_W), .SUB(1'b1)) u_cpa (
            .a_i (minuend),
            .b_i (subtrahend),
            .y_o (product_o)
        );
    end

    // Checkers on the output port, against an arithmetic product.
    logic [OUT_W-1:0] chk_prod;
    always_comb begin
        chk_prod = op_ext * OUT_W'(T14_CONST);

        a_r1_product_exact: assert (product_o == chk_prod)
            else $error("R1: product mismatch");

        a_r4_lsb_zero: assert (product_o[0] == 1'b0)
            else $error("R4: odd product");

        if (operand_i != '0) begin
            a_r5_sign_follows: assert (product_o[OUT_W-1] == operand_i[MSB])
                else $error("R5: sign mismatch");
        end else begin
            a_r8_zero_in_zero_out: assert (product_o == '0)
                else $error("R8: nonzero product for zero");
        end
    end
endmodule

// File: tb/times14_mul_bench.sv
// Bench: drives both builds with directed corners and seeded random operands.
module times14_mul_bench;
    logic        clk;
    logic        rst_n;
    logic [15:0] op;
    logic [19:0] prod_v0, prod_v1;
    int          n_tests;
    int          n_fail;
    bit          done;

    times14_mul #(.IN_W(16), .VARIANT(0)) u_times14_mul (
        .operand_i (op),
        .product_o (prod_v0)
    );

    times14_mul #(.IN_W(16), .VARIANT(1)) u_times14_mul_v1 (
        .operand_i (op),
        .product_o (prod_v1)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Reference product: integer arithmetic, truncated to 20 bits.
    function automatic logic [19:0] ref14(input logic [15:0] a);
        int v;
        v = int'($signed(a)) * 14;
        return v[19:0];
    endfunction

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%h actual=%h expected=%h", req, op, act, exp);
        end
    endtask

    // Apply on a rising edge, sample on the falling edge.
    task automatic apply(input logic [15:0] a);
        @(posedge clk);
        op = a;
        @(negedge clk);
        check("R1", prod_v0, ref14(a));
        check("R7", prod_v1, prod_v0);
        check("R4", {19'd0, prod_v0[0]}, 20'd0);
        if (a != 16'd0) check("R5", {19'd0, prod_v0[19]}, {19'd0, a[15]});
    endtask

    initial begin
        logic [31:0] seed_dummy;
        n_tests = 0;
        n_fail  = 0;
        done    = 1'b0;
        rst_n   = 1'b0;
        op      = 16'd0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R8: quiescent state with a zero operand.
        @(negedge clk);
        check("R8", prod_v0, 20'd0);
        check("R8", prod_v1, 20'd0);

        // R6: extremes of the operand range.
        apply(16'h7FFF);
        check("R6", prod_v0, 20'h6FFF2);
        apply(16'h8000);
        check("R6", prod_v0, 20'h90000);

        apply(16'h0001);
        check("R1", prod_v0, 20'd14);
        apply(16'hFFFF);
        check("R5", prod_v0, 20'hFFFF2);

        // R2 and R3: dense and alternating carry patterns through the compressor.
        apply(16'h5555);
        apply(16'hAAAA);
        apply(16'h7FFE);
        apply(16'h0000);
        check("R8", prod_v1, 20'd0);

        seed_dummy = $urandom(32'd1405);
        for (int i = 0; i < 3000; i++) begin
            apply(16'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a stalled run counts as one failure.
    initial begin
        #(10 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule